// File: doc/BRIEF.md
# Escalating Multi-Stage Watchdog

This block guards a system against a stuck processor. A built-in down-counting tick timer runs continuously. While the watchdog is running, every tick expiry pushes an expiration level one step further up a ladder of five stages: local interrupt, fast interrupt, remote interrupt, debug reset and power-on reset. Software keeps the level at zero by issuing start commands (pets) faster than one tick period. If the pets stop, the stages fire one after another, each only if its enable bit is set.

A per-stage skip count lets software jump over later stages. The time software sees before a reset is therefore one tick period times the number of stages it has not skipped. An error output compares the current level with a programmed threshold. Stopping the watchdog needs a key written to an unlock register just before the stop command, so that a stray write cannot switch it off. Configuration is frozen while the watchdog runs.

All access goes through a single-cycle write strobe with a byte address and a combinational read port.

Top module: `escalating_watchdog`

## Requirements
- R1: After reset the watchdog is stopped with level 0. The config register (offset 0x00) reads 0x0070_0000, meaning threshold 7 with every stage disabled. The status, skip and timer registers read 0, and every output is low.
- R2: Writing bit 0 of the command register (offset 0x08) is a pet. It sets running, clears the level to 0 and reloads the tick count, so the next expiry comes one full period later.
- R3: While running, each tick expiry moves the level from L to min(5, L+1+skip[L]). Here skip[L] is the 3-bit field at bits [4L+2:4L] of the skip register (offset 0x10). Level 5 saturates.
- R4: When an expiry lands on stage s (new level s+1), output stage_pulse[s] for s in 0..3 is high for exactly one cycle, provided config bit 12+s is set. Disabled stages and stages jumped over give no pulse.
- R5: When the level reaches 5 and config bit 16 is set, por_reset rises and stays high until rst_n, even across pets.
- R6: err_out is high exactly while level >= threshold, where the threshold is config bits [22:20].
- R7: Command bit 1 stops the watchdog only if the previous write to the unlock register (offset 0x0C) carried 0xC45A in bits [15:0], and no command write has come since. Any command write clears the unlock. A stop freezes the level.
- R8: While running, config writes are ignored. While stopped they store the source index [3:0], periodic bit 4, the enables [16:12] and the threshold [22:20].
- R9: The status register (offset 0x04) shows running in bit 0 and the level in bits [14:12]. Bit 1 is a pending-interrupt flag: it is set when the local-interrupt stage fires while enabled, and cleared by a pet.
- R10: The tick timer register (offset 0x14) holds the reload value in bits [28:0], periodic mode in bit 30 and enable in bit 31. An enabled timer expires every reload+1 cycles. In one-shot mode it clears its own enable bit after the first expiry.
- R11: Each timer expiry sets tick_irq, which reads back as bit 30 of the timer status register (offset 0x18). Writing 1 to that bit clears it; writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| stage_pulse | output | STAGES-1 | One-cycle pulses for local irq, fast irq, remote irq and debug reset |
| por_reset | output | 1 | Sticky power-on reset request |
| err_out | output | 1 | Level is at or above the threshold |
| tick_irq | output | 1 | Tick timer interrupt flag |

## Verification
Random trials draw skip counts, enables, thresholds, tick periods and a number of expiries. The bench then compares level, per-stage pulse counts, the sticky reset, the error output and the pending flag against a step model. A design that indexes skip by the new level instead of the old one, or that fires the stages it jumped over, ends on the wrong level or the wrong pulse count. Directed cases go after the unlock rule: a wrong key, and a key spent by an intervening pet, must both leave the watchdog running. A design that keeps the unlock alive would stop on the second case. Further directed cases cover the config freeze, saturation at level 5 with the reset staying high after a pet, the one-shot timer dropping its enable, and the write-one-to-clear timer flag.

// File: rtl/escalating_watchdog.sv
module escalating_watchdog #(
  parameter int          ADDR_W     = 5,
  parameter int          TICK_W     = 29,
  parameter int          STAGES     = 5,
  parameter int          SKIP_W     = 3,
  parameter logic [15:0] UNLOCK_KEY = 16'hC45A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [STAGES-2:0] stage_pulse,
  output logic              por_reset,
  output logic              err_out,
  output logic              tick_irq
);
  localparam int LVL_W = $clog2(STAGES + 1);
  localparam int SUM_W = LVL_W + SKIP_W;

  logic [3:0]                   src_sel;
  logic                         per_sel;
  logic [STAGES-1:0]            stage_en;
  logic [2:0]                   thr;
  logic [STAGES-1:0][SKIP_W-1:0] skip_q;
  logic                         running, unlocked, wd_irq;
  logic                         tmr_en, tmr_per;
  logic [TICK_W-1:0]            reload, cnt;
  logic [LVL_W-1:0]             level, lvl_nxt;
  logic [SKIP_W-1:0]            sel_skip;
  logic [SUM_W-1:0]             sum;
  logic [STAGES-1:0]            fire;

  wire wr_cfg  = bus_wr && bus_addr == ADDR_W'(8'h00);
  wire wr_cmd  = bus_wr && bus_addr == ADDR_W'(8'h08);
  wire wr_unl  = bus_wr && bus_addr == ADDR_W'(8'h0C);
  wire wr_skip = bus_wr && bus_addr == ADDR_W'(8'h10);
  wire wr_tmr  = bus_wr && bus_addr == ADDR_W'(8'h14);
  wire wr_tsts = bus_wr && bus_addr == ADDR_W'(8'h18);

  wire cmd_stop  = wr_cmd && bus_wdata[1] && unlocked;
  wire cmd_start = wr_cmd && bus_wdata[0] && !cmd_stop;
  wire tick_exp  = tmr_en && cnt == '0;
  wire advance   = running && tick_exp && !wr_cmd && level < LVL_W'(STAGES);

  always_comb begin
    sel_skip = '0;
    for (int i = 0; i < STAGES; i++)
      if (level == LVL_W'(i)) sel_skip = skip_q[i];
    sum     = SUM_W'(level) + SUM_W'(sel_skip) + SUM_W'(1);
    lvl_nxt = (sum > SUM_W'(STAGES)) ? LVL_W'(STAGES) : sum[LVL_W-1:0];
    fire    = '0;
    for (int i = 0; i < STAGES; i++)
      if (advance && lvl_nxt == LVL_W'(i + 1)) fire[i] = stage_en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= '0; per_sel <= 1'b0; stage_en <= '0; thr <= 3'd7;
      skip_q <= '0; running <= 1'b0; unlocked <= 1'b0; wd_irq <= 1'b0;
      level <= '0; stage_pulse <= '0; por_reset <= 1'b0;
    end else begin
      if (wr_cfg && !running) begin
        src_sel  <= bus_wdata[3:0];
        per_sel  <= bus_wdata[4];
        stage_en <= bus_wdata[12 +: STAGES];
        thr      <= bus_wdata[22:20];
      end
      if (wr_skip)
        for (int i = 0; i < STAGES; i++) skip_q[i] <= bus_wdata[4*i +: SKIP_W];
      if (wr_cmd)      unlocked <= 1'b0;
      else if (wr_unl) unlocked <= bus_wdata[15:0] == UNLOCK_KEY;
      if (cmd_stop) running <= 1'b0;
      else if (cmd_start) begin
        running <= 1'b1;
        level   <= '0;
      end else if (advance) level <= lvl_nxt;
      if (cmd_start)    wd_irq <= 1'b0;
      else if (fire[0]) wd_irq <= 1'b1;
      stage_pulse <= fire[STAGES-2:0];
      por_reset   <= por_reset | fire[STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en <= 1'b0; tmr_per <= 1'b0; reload <= '0; cnt <= '0; tick_irq <= 1'b0;
    end else begin
      if (wr_tmr) begin
        tmr_en  <= bus_wdata[31];
        tmr_per <= bus_wdata[30];
        reload  <= bus_wdata[TICK_W-1:0];
        cnt     <= bus_wdata[TICK_W-1:0];
      end else if (cmd_start) cnt <= reload;
      else if (tick_exp) begin
        cnt <= reload;
        if (!tmr_per) tmr_en <= 1'b0;
      end else if (tmr_en) cnt <= cnt - 1'b1;
      tick_irq <= (tick_irq && !(wr_tsts && bus_wdata[30])) || tick_exp;
    end
  end

  assign err_out = 32'(level) >= 32'(thr);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(8'h00): begin
        bus_rdata[3:0] = src_sel;
        bus_rdata[4] = per_sel;
        bus_rdata[12 +: STAGES] = stage_en;
        bus_rdata[22:20] = thr;
      end
      ADDR_W'(8'h04): begin
        bus_rdata[0] = running;
        bus_rdata[1] = wd_irq;
        bus_rdata[12 +: LVL_W] = level;
      end
      ADDR_W'(8'h10):
        for (int i = 0; i < STAGES; i++) bus_rdata[4*i +: SKIP_W] = skip_q[i];
      ADDR_W'(8'h14): begin
        bus_rdata[TICK_W-1:0] = reload;
        bus_rdata[30] = tmr_per;
        bus_rdata[31] = tmr_en;
      end
      ADDR_W'(8'h18): bus_rdata[30] = tick_irq;
      default: bus_rdata = '0;
    endcase
  end

  p_level_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(STAGES));
  p_level_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running && !wr_cmd |=> level >= $past(level));
  p_pet_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> running && level == '0);
  p_pulse_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |stage_pulse |-> level != $past(level));
  p_por_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    por_reset |=> por_reset);
  p_stop_needs_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running && wr_cmd && !unlocked |=> running);
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running && wr_cfg |=> $stable({stage_en, thr, src_sel, per_sel}));
endmodule

// File: tb/tb_escalating_watchdog.sv
module tb_escalating_watchdog;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_CFG = 5'h00, A_STS = 5'h04, A_CMD = 5'h08,
                         A_UNL = 5'h0C, A_SKP = 5'h10, A_TMR = 5'h14, A_TST = 5'h18;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] stage_pulse;
  logic por_reset, err_out, tick_irq;
  int checks = 0, errors = 0;
  int pcnt [4];

  escalating_watchdog dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stage_pulse(stage_pulse),
    .por_reset(por_reset), .err_out(err_out), .tick_irq(tick_irq));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk)
    for (int i = 0; i < 4; i++) if (stage_pulse[i]) pcnt[i]++;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(posedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic clr_pcnt();
    for (int i = 0; i < 4; i++) pcnt[i] = 0;
  endtask

  function automatic int nxt(int l, logic [19:0] sk);
    int n;
    if (l >= 5) return 5;
    n = l + 1 + int'(sk[4*l +: 3]);
    return (n > 5) ? 5 : n;
  endfunction

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    clr_pcnt();
    do_reset();
    // R1 reset state
    rd(A_CFG, d); chk("R1 cfg", d, 32'h0070_0000);
    rd(A_STS, d); chk("R1 status", d, 0);
    rd(A_SKP, d); chk("R1 skip", d, 0);
    rd(A_TMR, d); chk("R1 timer", d, 0);
    chk("R1 outputs", {stage_pulse, por_reset, err_out, tick_irq}, 0);

    // R8 config frozen while running
    wr(A_CFG, 32'h0071_F013);
    wr(A_TMR, 32'hC000_0007);
    wr(A_CMD, 1);
    wr(A_CFG, 32'h0);
    rd(A_CFG, d); chk("R8 cfg held while running", d, 32'h0071_F013);

    // R7 unlock rules
    wr(A_CMD, 2);
    rd(A_STS, d); chk("R7 stop without key", d[0], 1);
    wr(A_UNL, 32'h0000_C45B); wr(A_CMD, 2);
    rd(A_STS, d); chk("R7 stop with wrong key", d[0], 1);
    wr(A_UNL, 32'h0000_C45A); wr(A_CMD, 1); wr(A_CMD, 2);
    rd(A_STS, d); chk("R7 key spent by pet", d[0], 1);
    wr(A_CMD, 1);
    wr(A_UNL, 32'h0000_C45A); wr(A_CMD, 2);
    rd(A_STS, d); chk("R7 stop with key", d[0], 0);
    repeat (40) @(posedge clk); @(negedge clk);
    rd(A_STS, d); chk("R7 level frozen after stop", d[14:12], 0);
    wr(A_CFG, 32'h0020_1010);
    rd(A_CFG, d); chk("R8 cfg writable when stopped", d, 32'h0020_1010);

    // R3/R5 saturation and sticky reset
    do_reset();
    wr(A_CFG, 32'h0071_0010);
    wr(A_TMR, 32'hC000_0003);
    wr(A_CMD, 1);
    repeat (8 * 4) @(posedge clk); @(negedge clk); #1;
    rd(A_STS, d); chk("R3 saturate at 5", d[14:12], 5);
    chk("R5 por asserted", por_reset, 1);
    wr(A_CMD, 1);
    rd(A_STS, d); chk("R2 pet clears level", d[14:12], 0);
    chk("R5 por held across pet", por_reset, 1);
    do_reset();
    chk("R5 por cleared by reset", por_reset, 0);

    // R10/R11 one-shot timer and its flag
    wr(A_TMR, 32'h8000_0003);
    wr(A_CMD, 1);
    repeat (5 * 4) @(posedge clk); @(negedge clk); #1;
    rd(A_STS, d); chk("R10 one-shot gives one expiry", d[14:12], 1);
    rd(A_TMR, d); chk("R10 one-shot drops enable", d[31], 0);
    rd(A_TST, d); chk("R11 tick flag set", d[30], 1);
    wr(A_TST, 0);
    chk("R11 write 0 keeps flag", tick_irq, 1);
    wr(A_TST, 32'h4000_0000);
    rd(A_TST, d); chk("R11 write 1 clears flag", d[30], 0);

    // random trials for R3 R4 R5 R6 R9 R2
    for (int t = 0; t < 40; t++) begin
      logic [19:0] sk;
      logic [4:0] en;
      logic [2:0] th;
      int r, k, lv, n, hits[5];
      sk = '0;
      for (int i = 0; i < 5; i++)
        sk[4*i +: 3] = ($urandom % 3 == 0) ? 3'($urandom % 4) : 3'd0;
      en = 5'($urandom); th = 3'($urandom % 7); r = 2 + $urandom % 6; k = 1 + $urandom % 6;
      do_reset();
      wr(A_SKP, 32'(sk));
      wr(A_CFG, (32'(th) << 20) | (32'(en) << 12) | 32'h10);
      wr(A_TMR, 32'hC000_0000 | 32'(r));
      wr(A_CMD, 1);
      clr_pcnt();
      repeat (k * (r + 1)) @(posedge clk); @(negedge clk); #1;
      lv = 0;
      for (int i = 0; i < 5; i++) hits[i] = 0;
      for (int j = 0; j < k; j++) begin
        n = nxt(lv, sk);
        if (n != lv && en[n-1]) hits[n-1]++;
        lv = n;
      end
      rd(A_STS, d);
      chk("R3 level", d[14:12], lv);
      for (int i = 0; i < 4; i++) chk("R4 stage pulses", pcnt[i], hits[i]);
      chk("R5 por", por_reset, hits[4] > 0);
      chk("R6 err", err_out, lv >= int'(th));
      chk("R9 pending irq", d[1], hits[0] > 0);
      chk("R9 running", d[0], 1);
      wr(A_CMD, 1);
      rd(A_STS, d);
      chk("R2 pet clears level", d[14:12], 0);
      chk("R9 pet clears pending", d[1], 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule